// File: doc/BRIEF.md
# Sensorless Spindle Commutation Sequencer

This block steps a three-phase sensorless spindle motor through its six drive states. After the spindle is enabled it runs open loop: an external commutation strobe advances the drive state once per rising edge. It stays in that mode until its PHASE status output first rises. From then on, each accepted back-EMF zero crossing on the floating phase arms a programmable delay, and the drive advances when that delay expires.

A blanking window follows every step and hides the comparator input while the switching transient settles. A current-trip input starts a PWM off-time interval, and a 2-bit field sets its length. PHASE either toggles on every accepted crossing or runs at the back-EMF period, depending on the commutation mode bit. Analog sensing, filtering and output slew shaping sit outside the block and reach it as digital signals.

Top module: `spindle_commutator`

## Requirements
- R1: After reset, step_o is 0 and hi_on, lo_on, phase_o, sync_o and chop_off are all 0.
- R2: Phase bits are bit0=U, bit1=V, bit2=W. While brake is 1, hi_on=000 and lo_on=111. Otherwise, while spin_en is 0, both are 000. Otherwise step_o 0..5 drives hi/lo as U/V, U/W, V/W, V/U, W/U, W/V.
- R3: The block is running when spin_en=1 and brake=0. While it is not running, step_o, phase_o, sync_o, chop_off and all timers are cleared on the next edge. In the first cycle of a running interval (running now, not running in the previous cycle), sync_o is set on the next edge.
- R4: While sync_o is 1, a comm_strobe that is 1 after being 0 in the previous cycle advances step_o by one on the next edge (5 wraps to 0). While sync_o is 0, the strobe has no effect.
- R5: A zero crossing is accepted when the block is running, sense_en=1, no blanking is active, and zc_in differs from its value in the previous cycle. Any other change of zc_in is ignored.
- R6: Every step advance starts a blanking window of BLANK (default 6) cycles. Crossings in those cycles are ignored.
- R7: With ext_mode=1, phase_o toggles on every accepted crossing.
- R8: With ext_mode=0, phase_o toggles on every third accepted crossing, which gives a period of six crossings. The crossing count is kept in both modes and is cleared when the block stops running.
- R9: sync_o falls on the edge at which phase_o rises, unless that edge also begins a running interval.
- R10: An accepted crossing for which sync_o will be 0 after the edge loads a delay of DLY_UNIT<<delay_sel cycles (default DLY_UNIT=4). step_o advances exactly that many edges after the crossing, and a newer crossing restarts the delay.
- R11: pwm_trip while running and with chop_off=0 holds chop_off at 1 for OFF_UNIT<<offtime_sel cycles (default OFF_UNIT=8). Trips while chop_off is 1 are ignored.
- R12: hi_on and lo_on are each one-hot or zero, and they never share a phase unless brake is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master commutation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spin_en | input | 1 | Spindle enable |
| brake | input | 1 | Short-brake request |
| ext_mode | input | 1 | 1: PHASE toggles per crossing; 0: PHASE at back-EMF period |
| sense_en | input | 1 | Back-EMF crossing sense enable |
| comm_strobe | input | 1 | Open-loop commutation strobe |
| zc_in | input | 1 | Floating-phase comparator output |
| pwm_trip | input | 1 | Current-limit trip from the chopper comparator |
| delay_sel | input | 2 | Commutation delay select |
| offtime_sel | input | 2 | PWM off-time select |
| step_o | output | 3 | Current drive step 0..5 |
| hi_on | output | 3 | High-side enables {W,V,U} |
| lo_on | output | 3 | Low-side enables {W,V,U} |
| phase_o | output | 1 | PHASE status |
| sync_o | output | 1 | Synchronous (open-loop) interval active |
| chop_off | output | 1 | PWM off-time active |

## Verification
Two functions can act in the same cycle. One is the strobe-driven open-loop step. The other is the accepted zero crossing whose PHASE rise ends that open-loop interval and arms the first delayed step. A directed case raises comm_strobe and flips zc_in in the same cycle, with ext_mode set and blanking expired. The bench then expects step_o to advance once, sync_o to drop and phase_o to rise together. It also expects the next step exactly one delay later. Random traffic also produces this overlap, as well as a delay expiry that falls on a fresh crossing, and a cycle-accurate bench model judges each cycle.

// File: rtl/spc_pkg.sv
package spc_pkg;

  localparam int unsigned NUM_STEPS = 6;
  localparam int unsigned STEP_W    = 3;

  typedef logic [STEP_W-1:0] step_t;

  typedef struct packed {
    logic [2:0] hi;
    logic [2:0] lo;
  } drive_t;

  // Six-step table, phase bits {W,V,U}
  function automatic drive_t step_drive(step_t s);
    drive_t d;
    case (s)
      3'd0:    begin d.hi = 3'b001; d.lo = 3'b010; end
      3'd1:    begin d.hi = 3'b001; d.lo = 3'b100; end
      3'd2:    begin d.hi = 3'b010; d.lo = 3'b100; end
      3'd3:    begin d.hi = 3'b010; d.lo = 3'b001; end
      3'd4:    begin d.hi = 3'b100; d.lo = 3'b001; end
      3'd5:    begin d.hi = 3'b100; d.lo = 3'b010; end
      default: begin d.hi = 3'b000; d.lo = 3'b000; end
    endcase
    return d;
  endfunction

  function automatic step_t step_inc(step_t s);
    return (s == step_t'(NUM_STEPS - 1)) ? step_t'(0) : s + step_t'(1);
  endfunction

endpackage

// File: rtl/spc_zc_gate.sv
module spc_zc_gate #(
  parameter int unsigned BLANK = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sense_en,
  input  logic zc_in,
  input  logic step_adv,
  output logic accept,
  output logic blanking
);
  localparam int unsigned BW = $clog2(BLANK + 1) + 1;

  logic          zc_q, zc_d;
  logic [BW-1:0] blank_q, blank_d;

  always_comb begin
    zc_d = zc_in;
    if (!run)
      blank_d = '0;
    else if (step_adv)
      blank_d = BW'(BLANK);
    else if (blank_q != '0)
      blank_d = blank_q - BW'(1);
    else
      blank_d = blank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q    <= 1'b0;
      blank_q <= '0;
    end else begin
      zc_q    <= zc_d;
      blank_q <= blank_d;
    end
  end

  assign blanking = (blank_q != '0);
  assign accept   = run & sense_en & ~blanking & (zc_in ^ zc_q);

  // R6
  blank_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_adv) |=> !accept);

endmodule

// File: rtl/spc_delay_timer.sv
module spc_delay_timer #(
  parameter int unsigned DLY_UNIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       arm,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int unsigned MAXD = DLY_UNIT * 8;
  localparam int unsigned DW   = $clog2(MAXD + 1) + 1;

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)
      cnt_d = '0;
    else if (arm)
      cnt_d = DW'(DLY_UNIT) << sel;
    else if (cnt_q != '0)
      cnt_d = cnt_q - DW'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run & (cnt_q == DW'(1));

  // R10
  delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DW'(MAXD));

endmodule

// File: rtl/spc_chop_timer.sv
module spc_chop_timer #(
  parameter int unsigned OFF_UNIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       trip,
  input  logic [1:0] sel,
  output logic       chop
);
  localparam int unsigned MAXO = OFF_UNIT * 8;
  localparam int unsigned OW   = $clog2(MAXO + 1) + 1;

  logic [OW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)
      cnt_d = '0;
    else if (trip && cnt_q == '0)
      cnt_d = OW'(OFF_UNIT) << sel;
    else if (cnt_q != '0)
      cnt_d = cnt_q - OW'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign chop = (cnt_q != '0);

  // R11
  chop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chop) |-> $past(trip));

endmodule

// File: rtl/spindle_commutator.sv
module spindle_commutator #(
  parameter int unsigned BLANK    = 6,
  parameter int unsigned DLY_UNIT = 4,
  parameter int unsigned OFF_UNIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spin_en,
  input  logic       brake,
  input  logic       ext_mode,
  input  logic       sense_en,
  input  logic       comm_strobe,
  input  logic       zc_in,
  input  logic       pwm_trip,
  input  logic [1:0] delay_sel,
  input  logic [1:0] offtime_sel,
  output logic [2:0] step_o,
  output logic [2:0] hi_on,
  output logic [2:0] lo_on,
  output logic       phase_o,
  output logic       sync_o,
  output logic       chop_off
);
  import spc_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic       run, run_q;
  logic       strobe_q;
  logic       sync_q, sync_d;
  logic       phase_q, phase_d;
  logic [1:0] zcnt_q, zcnt_d;
  step_t      step_q, step_d;
  logic       accept, blanking, expire;
  logic       toggle, phase_rise, strobe_rise, adv, arm;
  drive_t     drv;

  assign run = spin_en & ~brake;

  spc_zc_gate #(.BLANK(BLANK)) u_zc (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .sense_en (sense_en),
    .zc_in    (zc_in),
    .step_adv (adv),
    .accept   (accept),
    .blanking (blanking)
  );

  spc_delay_timer #(.DLY_UNIT(DLY_UNIT)) u_dly (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (run),
    .arm    (arm),
    .sel    (delay_sel),
    .expire (expire)
  );

  spc_chop_timer #(.OFF_UNIT(OFF_UNIT)) u_chop (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .trip  (pwm_trip),
    .sel   (offtime_sel),
    .chop  (chop_off)
  );

  // next-state logic
  always_comb begin
    toggle      = accept & (ext_mode | (zcnt_q == 2'd2));
    phase_rise  = toggle & ~phase_q;
    strobe_rise = comm_strobe & ~strobe_q;

    if (!run)                  sync_d = 1'b0;
    else if (!run_q)           sync_d = 1'b1;
    else if (phase_rise)       sync_d = 1'b0;
    else                       sync_d = sync_q;

    adv = run & ((sync_q & strobe_rise) | expire);
    arm = accept & ~sync_d;

    if (!run)      step_d = '0;
    else if (adv)  step_d = step_inc(step_q);
    else           step_d = step_q;

    if (!run)         phase_d = 1'b0;
    else if (toggle)  phase_d = ~phase_q;
    else              phase_d = phase_q;

    if (!run)         zcnt_d = 2'd0;
    else if (accept)  zcnt_d = (zcnt_q == 2'd2) ? 2'd0 : zcnt_q + 2'd1;
    else              zcnt_d = zcnt_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q    <= 1'b0;
      strobe_q <= 1'b0;
      sync_q   <= 1'b0;
      phase_q  <= 1'b0;
      zcnt_q   <= 2'd0;
      step_q   <= '0;
    end else begin
      run_q    <= run;
      strobe_q <= comm_strobe;
      sync_q   <= sync_d;
      phase_q  <= phase_d;
      zcnt_q   <= zcnt_d;
      step_q   <= step_d;
    end
  end

  // output decode
  always_comb begin
    drv = step_drive(step_q);
    if (brake) begin
      hi_on = 3'b000;
      lo_on = 3'b111;
    end else if (!spin_en) begin
      hi_on = 3'b000;
      lo_on = 3'b000;
    end else begin
      hi_on = drv.hi;
      lo_on = drv.lo;
    end
  end

  assign step_o  = step_q;
  assign phase_o = phase_q;
  assign sync_o  = sync_q;

  // R4
  step_single_inc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_q != $past(step_q) && step_q != 3'd0) |-> step_q == $past(step_q) + 3'd1);

  // R9
  sync_exit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(sync_q) |-> ($rose(phase_q) || !$past(run)));

  // R10
  no_delay_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_q |-> !expire);

  // R12
  drive_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !brake |-> ($onehot0(hi_on) && $onehot0(lo_on) && (hi_on & lo_on) == 3'b000));

endmodule

// File: tb/spindle_commutator_tb.sv
module spindle_commutator_tb;

  localparam int BL = 6;
  localparam int DU = 4;
  localparam int OU = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic spin_en, brake, ext_mode, sense_en, comm_strobe, zc_in, pwm_trip;
  logic [1:0] delay_sel, offtime_sel;
  logic [2:0] step_o, hi_on, lo_on;
  logic phase_o, sync_o, chop_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  spindle_commutator u_dut (
    .clk(clk), .rst_n(rst_n), .spin_en(spin_en), .brake(brake),
    .ext_mode(ext_mode), .sense_en(sense_en), .comm_strobe(comm_strobe),
    .zc_in(zc_in), .pwm_trip(pwm_trip), .delay_sel(delay_sel),
    .offtime_sel(offtime_sel), .step_o(step_o), .hi_on(hi_on),
    .lo_on(lo_on), .phase_o(phase_o), .sync_o(sync_o), .chop_off(chop_off)
  );

  // bench model state
  int m_step, m_blank, m_dly, m_chop, m_cnt;
  bit m_sync, m_phase, m_zcd, m_strd, m_rund;

  function automatic logic [5:0] exp_drive(int s, bit en, bit brk);
    if (brk) return 6'b000_111;
    if (!en) return 6'b000_000;
    case (s)
      0: return 6'b001_010;
      1: return 6'b001_100;
      2: return 6'b010_100;
      3: return 6'b010_001;
      4: return 6'b100_001;
      default: return 6'b100_010;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_step = 0; m_blank = 0; m_dly = 0; m_chop = 0; m_cnt = 0;
    m_sync = 0; m_phase = 0; m_zcd = 0; m_strd = 0; m_rund = 0;
  endtask

  // one clock edge of the requirement model, using current inputs
  task automatic model_edge();
    bit run, acc, tog, prise, sync_n, srise, adv;
    int dly_n, blank_n, step_n, cnt_n, chop_n;
    bit phase_n;
    run    = spin_en & ~brake;
    acc    = run & sense_en & (m_blank == 0) & (zc_in != m_zcd);          // R5 R6
    tog    = acc & (ext_mode | (m_cnt == 2));                             // R7 R8
    prise  = tog & ~m_phase;
    sync_n = !run ? 0 : (!m_rund ? 1 : (prise ? 0 : m_sync));             // R3 R9
    srise  = comm_strobe & ~m_strd;
    adv    = run & ((m_sync & srise) | (m_dly == 1));                     // R4 R10
    dly_n  = !run ? 0 : ((acc && !sync_n) ? (DU << delay_sel) : (m_dly > 0 ? m_dly - 1 : 0));
    blank_n = !run ? 0 : (adv ? BL : (m_blank > 0 ? m_blank - 1 : 0));
    step_n = !run ? 0 : (adv ? (m_step == 5 ? 0 : m_step + 1) : m_step);
    phase_n = !run ? 0 : (tog ? ~m_phase : m_phase);
    cnt_n  = !run ? 0 : (acc ? (m_cnt == 2 ? 0 : m_cnt + 1) : m_cnt);
    chop_n = !run ? 0 : ((pwm_trip && m_chop == 0) ? (OU << offtime_sel)   // R11
                        : (m_chop > 0 ? m_chop - 1 : 0));
    m_step = step_n; m_blank = blank_n; m_dly = dly_n; m_chop = chop_n;
    m_cnt = cnt_n; m_sync = sync_n; m_phase = phase_n;
    m_zcd = zc_in; m_strd = comm_strobe; m_rund = run;
  endtask

  task automatic compare_all();
    logic [5:0] d;
    d = exp_drive(m_step, spin_en, brake);
    chk(step_o == 3'(m_step), "R4/R10 step", step_o, m_step);
    chk(hi_on == d[5:3], "R2 hi_on", hi_on, d[5:3]);
    chk(lo_on == d[2:0], "R2 lo_on", lo_on, d[2:0]);
    chk(phase_o == m_phase, "R7/R8 phase", phase_o, m_phase);
    chk(sync_o == m_sync, "R3/R9 sync", sync_o, m_sync);
    chk(chop_off == (m_chop != 0), "R11 chop", chop_off, m_chop != 0);
  endtask

  // inputs already applied at a negedge; advance one cycle and compare
  task automatic cycle();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_0c0d;
    void'($urandom(seed));
    rst_n = 0; spin_en = 0; brake = 0; ext_mode = 1; sense_en = 1;
    comm_strobe = 0; zc_in = 0; pwm_trip = 0; delay_sel = 0; offtime_sel = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(step_o == 0 && hi_on == 0 && lo_on == 0, "R1 drive", {step_o, hi_on, lo_on}, 0);
    chk(!phase_o && !sync_o && !chop_off, "R1 flags", {phase_o, sync_o, chop_off}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all();

    // directed: strobe stepping, then strobe and ending crossing together
    spin_en = 1;
    cycle();
    chk(sync_o == 1, "R3 sync on enable", sync_o, 1);
    comm_strobe = 1; cycle();
    chk(step_o == 1, "R4 strobe step", step_o, 1);
    comm_strobe = 0;
    repeat (8) cycle();
    comm_strobe = 1; zc_in = 1; cycle();
    chk(step_o == 2 && sync_o == 0 && phase_o == 1, "R9 same-cycle handover",
        {step_o, sync_o, phase_o}, {3'd2, 1'b0, 1'b1});
    comm_strobe = 0;
    repeat (3) cycle();
    chk(step_o == 2, "R10 before delay", step_o, 2);
    cycle();
    chk(step_o == 3, "R10 delay expiry", step_o, 3);
    // strobe ignored out of sync
    comm_strobe = 1; cycle(); comm_strobe = 0; cycle();
    chk(step_o == 3, "R4 strobe ignored", step_o, 3);
    // crossing inside blanking ignored: step advanced 2 cycles ago
    zc_in = 0; cycle();
    repeat (12) cycle();
    chk(step_o == 3 && phase_o == 1, "R6 blanked crossing", {step_o, phase_o}, {3'd3, 1'b1});
    // brake
    brake = 1; cycle();
    chk(hi_on == 0 && lo_on == 3'b111 && step_o == 0, "R2 brake", {hi_on, lo_on}, 7);
    brake = 0;
    repeat (2) cycle();

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) spin_en = ~spin_en;
      if (!spin_en && $urandom_range(0, 9) == 0) spin_en = 1;
      if ($urandom_range(0, 299) == 0) brake = 1;
      else if (brake && $urandom_range(0, 7) == 0) brake = 0;
      if ($urandom_range(0, 299) == 0) ext_mode = ~ext_mode;
      sense_en = ($urandom_range(0, 49) != 0);
      if ($urandom_range(0, 3) == 0) comm_strobe = ~comm_strobe;
      if ($urandom_range(0, 9) == 0) zc_in = ~zc_in;
      pwm_trip = ($urandom_range(0, 14) == 0);
      if ($urandom_range(0, 99) == 0) delay_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 99) == 0) offtime_sel = 2'($urandom_range(0, 3));
      cycle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule